// File: doc/BRIEF.md
# Key-Protected Reset and Power Control Register

This block is a 32-bit control word for a data converter. It holds three things: an 8-bit unlock key, two alarm-disable flags, and three power and reset settings. The settings are a reset-class select, a nap enable and a power-down request. Software writes single bytes at byte addresses and reads back the whole word at its word address.

The six control bits only change while the key field already holds the unlock value 69h. The block also watches an external reset pin. It passes that pin through a synchroniser. It then decides whether the pin clears the whole register (full class) or only the user-set fields (application class).

Once power-down has been requested, the pin is forced to application class until the next power-on reset. The block drives the alarm enables, a power-down request, and a nap request. The nap request follows chip-select and a conversion-done pulse.

Top module: `rst_pwr_ctl`

## Requirements
- R1: While `por_n` is low at a rising edge, the whole word clears to zero. After release, `rd_data` at address 04h reads 00000000h, both alarm enables are 1, and `nap_req` and `pwrdn_req` are 0.
- R2: A write to byte address 05h loads the key into word bits 15:8. Writes to byte addresses 06h and 07h change nothing, and word bits 31:16 always read 0.
- R3: A write to byte address 04h updates the control bits only when the key already holds 69h before that write. Otherwise the control bits keep their values. A key of any other value, such as 68h, locks them again.
- R4: In the byte written at 04h, bit 5 is the supply-alarm disable, bit 4 the input-alarm disable, bit 2 the reset class, bit 1 the nap enable and bit 0 power-down. Word bits 7:6 and 3 always read 0, even after a write of FFh.
- R5: `supply_alarm_en` is the inverse of bit 5, and `input_alarm_en` is the inverse of bit 4.
- R6: With bit 2 at 0 and power-down never set since power-on, a low level on `rst_pin_n` clears the whole word. This starts at the third rising edge after the pin is first sampled low, and it also clears `nap_req`.
- R7: With bit 2 at 1, a pin reset clears only the key and bits 5:4. Bits 2:0 keep their values.
- R8: Once bit 0 has been 1, every later pin reset is application class, even after bit 0 and bit 2 are cleared. This lasts until `por_n` is asserted.
- R9: With bit 1 at 1 and `csel` high, a `conv_done` pulse raises `nap_req` at the next edge. With bit 1 at 0, `nap_req` stays 0.
- R10: `nap_req` falls at the first rising edge at which `csel` is low.
- R11: `pwrdn_req` equals word bit 0 at all times.
- R12: `rd_data` is 0 for any read address other than 04h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, sampled at the clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Byte write address |
| wr_data | input | 8 | Byte write data |
| rd_addr | input | 8 | Word read address |
| rd_data | output | 32 | Read word, combinational |
| csel | input | 1 | Chip-select level, high when the host is idle |
| conv_done | input | 1 | One-cycle pulse when a conversion ends |
| supply_alarm_en | output | 1 | Supply alarm enabled |
| input_alarm_en | output | 1 | Input alarm enabled |
| nap_req | output | 1 | Nap request to the converter core |
| pwrdn_req | output | 1 | Power-down request to the converter core |

## Verification
A wrong key or lock state appears on the read port in the cycle after the next write to address 04h. In that cycle, either a control bit changes that should not, or it fails to change when it should. A wrong sticky flag or reset-class decision stays hidden until a pin reset arrives. It then shows three edges after the pin falls, as nonzero bits 2:0 where zeros were due, or the reverse. The reference model compares every output on every clock, so any of these divergences is caught in the first cycle it becomes visible.

// File: rtl/rpc_pkg.sv
// Shared constants and types for the reset and power control register.
// Assumes a fixed byte lane layout for the 32-bit word.
package rpc_pkg;
    localparam int WORD_W = 32;
    localparam int KEY_W  = 8;

    // Control bit positions within the low byte; the core decodes these.
    localparam int B_PD  = 0;
    localparam int B_NAP = 1;
    localparam int B_CLS = 2;
    localparam int B_IN  = 4;
    localparam int B_VDD = 5;

    typedef struct packed {
        logic vdd_dis;
        logic in_dis;
        logic rst_cls;
        logic nap_en;
        logic pwrdn;
    } ctl_t;

    // Assemble the readable word from key and control fields.
    function automatic logic [WORD_W-1:0] pack_word(logic [KEY_W-1:0] key, ctl_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[15:8]  = key;
        w[B_VDD] = c.vdd_dis;
        w[B_IN]  = c.in_dis;
        w[B_CLS] = c.rst_cls;
        w[B_NAP] = c.nap_en;
        w[B_PD]  = c.pwrdn;
        return w;
    endfunction
endpackage

// File: rtl/rpc_pin_sync.sv
// Synchroniser for the asynchronous active-low reset pin.
// Assumes STAGES >= 2; output is high while the synchronised pin is low.
module rpc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    output logic pin_act
);
    logic [STAGES-1:0] stage_q;

    // Shift the pin level through the flop chain; idle level is high.
    always_ff @(posedge clk) begin
        if (!por_n) stage_q[0] <= 1'b1;
        else        stage_q[0] <= pin_n;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_chain
        // Next synchroniser stage.
        always_ff @(posedge clk) begin
            if (!por_n) stage_q[i] <= 1'b1;
            else        stage_q[i] <= stage_q[i-1];
        end
    end

    assign pin_act = !stage_q[STAGES-1];
endmodule

// File: rtl/rpc_reset_ctrl.sv
// Picks the reset class for a synchronised pin assertion.
// Keeps a sticky flag, set by power-down, that forces application class
// until power-on reset. Assumes por_n is synchronous, active low.
module rpc_reset_ctrl (
    input  logic clk,
    input  logic por_n,
    input  logic pin_act_i,
    input  logic rst_cls_i,
    input  logic pwrdn_i,
    output logic full_rst_o,
    output logic app_rst_o
);
    logic sticky_q;
    logic force_app;

    // Remember that power-down was requested at any time since power-on.
    always_ff @(posedge clk) begin
        if (!por_n)       sticky_q <= 1'b0;
        else if (pwrdn_i) sticky_q <= 1'b1;
    end

    // Application class if selected, if power-down is set now, or if it was set before.
    always_comb begin
        force_app  = rst_cls_i || pwrdn_i || sticky_q;
        full_rst_o = pin_act_i && !force_app;
        app_rst_o  = pin_act_i && force_app;
    end

    AST_STICKY_APP: assert property (@(posedge clk) disable iff (!por_n)
        (sticky_q && pin_act_i) |-> (app_rst_o && !full_rst_o)); // R8
    AST_CLS_APP: assert property (@(posedge clk) disable iff (!por_n)
        (rst_cls_i && pin_act_i) |-> !full_rst_o); // R7
endmodule

// File: rtl/rpc_regfile.sv
// Key and control-bit storage with byte-addressed writes.
// The key is checked before the same write can change it. Full reset
// clears all; application reset clears key and alarm disables only.
module rpc_regfile
    import rpc_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h04,
    parameter logic [KEY_W-1:0]  KEY_VAL   = 8'h69
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              full_rst_i,
    input  logic              app_rst_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    output logic [KEY_W-1:0]  key_o,
    output ctl_t              ctl_o
);
    localparam logic [ADDR_W-1:0] KEY_ADDR = BASE_ADDR + 1'b1;

    logic [KEY_W-1:0] key_q;
    ctl_t             ctl_q;
    logic             ctl_wr;
    logic             key_wr;
    logic             unused_bits;

    assign ctl_wr      = wr_en_i && (wr_addr_i == BASE_ADDR) && (key_q == KEY_VAL);
    assign key_wr      = wr_en_i && (wr_addr_i == KEY_ADDR);
    assign unused_bits = ^{wr_data_i[7:6], wr_data_i[3]};

    // Key register: cleared by either reset class, loaded from its byte lane.
    always_ff @(posedge clk) begin
        if (!por_n || full_rst_i || app_rst_i) key_q <= '0;
        else if (key_wr)                       key_q <= wr_data_i;
    end

    // Alarm disables: user fields, cleared by both reset classes.
    always_ff @(posedge clk) begin
        if (!por_n || full_rst_i || app_rst_i) begin
            ctl_q.vdd_dis <= 1'b0;
            ctl_q.in_dis  <= 1'b0;
        end else if (ctl_wr) begin
            ctl_q.vdd_dis <= wr_data_i[B_VDD];
            ctl_q.in_dis  <= wr_data_i[B_IN];
        end
    end

    // Power and reset-class bits: cleared only by full-class reset.
    always_ff @(posedge clk) begin
        if (!por_n || full_rst_i) begin
            ctl_q.rst_cls <= 1'b0;
            ctl_q.nap_en  <= 1'b0;
            ctl_q.pwrdn   <= 1'b0;
        end else if (ctl_wr && !app_rst_i) begin
            ctl_q.rst_cls <= wr_data_i[B_CLS];
            ctl_q.nap_en  <= wr_data_i[B_NAP];
            ctl_q.pwrdn   <= wr_data_i[B_PD];
        end
    end

    assign key_o = key_q;
    assign ctl_o = ctl_q;

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (!full_rst_i && !app_rst_i && !(wr_en_i && wr_addr_i == BASE_ADDR && key_q == KEY_VAL))
        |=> $stable(ctl_q)); // R3
    AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
        full_rst_i |=> (key_q == '0 && ctl_q == '0)); // R6
    AST_APP_KEEP: assert property (@(posedge clk) disable iff (!por_n)
        (app_rst_i && !full_rst_i) |=> ($stable({ctl_q.rst_cls, ctl_q.nap_en, ctl_q.pwrdn})
                                        && key_q == '0 && !ctl_q.vdd_dis && !ctl_q.in_dis)); // R7
endmodule

// File: rtl/rpc_nap.sv
// Nap request handshake: rises after a conversion ends while chip-select
// is high and nap is enabled; drops when chip-select goes low or nap is off.
module rpc_nap (
    input  logic clk,
    input  logic por_n,
    input  logic full_rst_i,
    input  logic nap_en_i,
    input  logic csel_i,
    input  logic conv_done_i,
    output logic nap_req_o
);
    logic nap_req_q;

    // Track the nap state from chip-select and conversion completion.
    always_ff @(posedge clk) begin
        if (!por_n || full_rst_i)       nap_req_q <= 1'b0;
        else if (!csel_i || !nap_en_i)  nap_req_q <= 1'b0;
        else if (conv_done_i)           nap_req_q <= 1'b1;
    end

    assign nap_req_o = nap_req_q;

    AST_NAP_OFF: assert property (@(posedge clk) disable iff (!por_n)
        !nap_en_i |=> !nap_req_q); // R9
    AST_NAP_SET: assert property (@(posedge clk) disable iff (!por_n)
        (csel_i && nap_en_i && conv_done_i && !full_rst_i) |=> nap_req_q); // R9
    AST_NAP_CS_LOW: assert property (@(posedge clk) disable iff (!por_n)
        !csel_i |=> !nap_req_q); // R10
endmodule

// File: rtl/rst_pwr_ctl.sv
// Top of the key-protected reset and power control register.
// Assumes single-byte writes, a combinational word read and a synchronous
// active-low power-on reset; the reset pin is asynchronous.
module rst_pwr_ctl
    import rpc_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h04,
    parameter logic [KEY_W-1:0]  KEY_VAL     = 8'h69,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_pin_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              csel,
    input  logic              conv_done,
    output logic              supply_alarm_en,
    output logic              input_alarm_en,
    output logic              nap_req,
    output logic              pwrdn_req
);
    logic             pin_act;
    logic             full_rst;
    logic             app_rst;
    logic [KEY_W-1:0] key;
    ctl_t             ctl;

    rpc_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .por_n   (por_n),
        .pin_n   (rst_pin_n),
        .pin_act (pin_act)
    );

    rpc_reset_ctrl i_rstc (
        .clk        (clk),
        .por_n      (por_n),
        .pin_act_i  (pin_act),
        .rst_cls_i  (ctl.rst_cls),
        .pwrdn_i    (ctl.pwrdn),
        .full_rst_o (full_rst),
        .app_rst_o  (app_rst)
    );

    rpc_regfile #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .KEY_VAL(KEY_VAL)) i_regs (
        .clk        (clk),
        .por_n      (por_n),
        .full_rst_i (full_rst),
        .app_rst_i  (app_rst),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .key_o      (key),
        .ctl_o      (ctl)
    );

    rpc_nap i_nap (
        .clk         (clk),
        .por_n       (por_n),
        .full_rst_i  (full_rst),
        .nap_en_i    (ctl.nap_en),
        .csel_i      (csel),
        .conv_done_i (conv_done),
        .nap_req_o   (nap_req)
    );

    // Word read and core-facing control outputs.
    always_comb begin
        rd_data         = (rd_addr == BASE_ADDR) ? pack_word(key, ctl) : '0;
        supply_alarm_en = !ctl.vdd_dis;
        input_alarm_en  = !ctl.in_dis;
        pwrdn_req       = ctl.pwrdn;
    end

    AST_NO_FULL_AFTER_PD: assert property (@(posedge clk) disable iff (!por_n)
        pwrdn_req |=> !full_rst); // R8
endmodule

// File: tb/test_rst_pwr_ctl.sv
module test_rst_pwr_ctl;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_pin_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_addr = 8'h04;
    logic [31:0] rd_data;
    logic        csel = 1'b1;
    logic        conv_done = 1'b0;
    logic        supply_alarm_en, input_alarm_en, nap_req, pwrdn_req;

    int total = 0;
    int bad   = 0;
    bit mdl_on = 0;

    always #4 clk = ~clk;

    rst_pwr_ctl i_rst_pwr_ctl (
        .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .csel(csel), .conv_done(conv_done),
        .supply_alarm_en(supply_alarm_en), .input_alarm_en(input_alarm_en),
        .nap_req(nap_req), .pwrdn_req(pwrdn_req)
    );

    // Behavioural reference state.
    int m_key = 0, m_vdd = 0, m_in = 0, m_cls = 0, m_nap = 0, m_pd = 0;
    int m_sticky = 0, m_napreq = 0;
    int m_pin[$] = '{1, 1};

    always @(posedge clk) begin
        int pin_on, full, app, n_napreq;
        if (!por_n) begin
            m_key = 0; m_vdd = 0; m_in = 0; m_cls = 0; m_nap = 0; m_pd = 0;
            m_sticky = 0; m_napreq = 0; m_pin = '{1, 1};
        end else begin
            pin_on = (m_pin[0] == 0);
            full = pin_on && !m_cls && !m_pd && !m_sticky;
            app  = pin_on && !full;
            if (m_pd) m_sticky = 1;
            void'(m_pin.pop_front());
            m_pin.push_back(int'(rst_pin_n));
            if (full) n_napreq = 0;
            else if (!csel || !m_nap) n_napreq = 0;
            else if (conv_done) n_napreq = 1;
            else n_napreq = m_napreq;
            if (full) begin
                m_key = 0; m_vdd = 0; m_in = 0; m_cls = 0; m_nap = 0; m_pd = 0;
            end else if (app) begin
                m_key = 0; m_vdd = 0; m_in = 0;
            end else if (wr_en && wr_addr == 8'h05) begin
                m_key = int'(wr_data);
            end else if (wr_en && wr_addr == 8'h04 && m_key == 'h69) begin
                m_vdd = wr_data[5]; m_in = wr_data[4]; m_cls = wr_data[2];
                m_nap = wr_data[1]; m_pd = wr_data[0];
            end
            m_napreq = n_napreq;
        end
    end

    function automatic logic [31:0] m_word();
        logic [31:0] w = '0;
        w[15:8] = m_key[7:0];
        w[5] = m_vdd[0]; w[4] = m_in[0]; w[2] = m_cls[0]; w[1] = m_nap[0]; w[0] = m_pd[0];
        return w;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the reference model.
    always @(negedge clk) begin
        if (mdl_on) begin
            chk("R12/R2 rd_data", rd_data, (rd_addr == 8'h04) ? m_word() : 32'h0);
            chk("R5 supply_alarm_en", {31'h0, supply_alarm_en}, {31'h0, !m_vdd[0]});
            chk("R5 input_alarm_en", {31'h0, input_alarm_en}, {31'h0, !m_in[0]});
            chk("R9/R10 nap_req", {31'h0, nap_req}, {31'h0, m_napreq[0]});
            chk("R11 pwrdn_req", {31'h0, pwrdn_req}, {31'h0, m_pd[0]});
        end
    end

    task automatic wr(logic [7:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pin_pulse();
        rst_pin_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_pin_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic por_pulse();
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        mdl_on = 1;
        // R1 reset state
        chk("R1 word", rd_data, 32'h0);
        chk("R1 alarms", {30'h0, supply_alarm_en, input_alarm_en}, 32'h3);
        chk("R1 requests", {30'h0, nap_req, pwrdn_req}, 32'h0);
        // R3 locked write ignored; R2 upper lanes inert
        wr(8'h04, 8'h3F);
        chk("R3 locked", rd_data, 32'h0);
        wr(8'h06, 8'hFF); wr(8'h07, 8'hFF);
        chk("R2 upper lanes", rd_data, 32'h0);
        wr(8'h05, 8'h69);
        chk("R2 key lane", rd_data, 32'h0000_6900);
        wr(8'h04, 8'h30);
        chk("R5 alarms disabled word", rd_data, 32'h0000_6930);
        chk("R5 alarm outputs", {30'h0, supply_alarm_en, input_alarm_en}, 32'h0);
        wr(8'h04, 8'hC8);
        chk("R4 reserved bits", rd_data, 32'h0000_6900);
        // R9 / R10 nap
        wr(8'h04, 8'h32);
        csel = 1'b1; conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        chk("R9 nap rises", {31'h0, nap_req}, 32'h1);
        csel = 1'b0;
        @(negedge clk);
        chk("R10 nap falls", {31'h0, nap_req}, 32'h0);
        csel = 1'b1;
        wr(8'h04, 8'h30);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        chk("R9 nap disabled", {31'h0, nap_req}, 32'h0);
        // R6 full-class pin reset
        pin_pulse();
        chk("R6 full reset", rd_data, 32'h0);
        // R7 application-class pin reset
        wr(8'h05, 8'h69);
        wr(8'h04, 8'h36);
        chk("R7 before", rd_data, 32'h0000_6936);
        pin_pulse();
        chk("R7 app reset keeps 2:0", rd_data, 32'h0000_0006);
        // R3 key overwritten locks again
        wr(8'h05, 8'h68);
        wr(8'h04, 8'h00);
        chk("R3 relocked", rd_data, 32'h0000_6806);
        // R8 sticky after power-down
        por_pulse();
        chk("R1 after por", rd_data, 32'h0);
        wr(8'h05, 8'h69);
        wr(8'h04, 8'h01);
        chk("R11 pwrdn set", {31'h0, pwrdn_req}, 32'h1);
        wr(8'h04, 8'h32);
        chk("R8 pd cleared", rd_data, 32'h0000_6932);
        pin_pulse();
        chk("R8 sticky app reset", rd_data, 32'h0000_0002);
        por_pulse();
        wr(8'h05, 8'h69);
        wr(8'h04, 8'h02);
        pin_pulse();
        chk("R8 sticky cleared by por", rd_data, 32'h0);
        // R12 other read addresses
        wr(8'h05, 8'h69);
        rd_addr = 8'h05;
        @(negedge clk);
        chk("R12 addr 05", rd_data, 32'h0);
        rd_addr = 8'h00;
        @(negedge clk);
        chk("R12 addr 00", rd_data, 32'h0);
        rd_addr = 8'h04;
        @(negedge clk);
        chk("R2 key visible", rd_data, 32'h0000_6900);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule